// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit

This block is the carry-chain arithmetic slice of an 8-bit processor datapath. Each cycle it takes an accumulator byte, an operand byte, a carry input, a decimal-mode flag and a two-bit operation code. It returns the sum or difference, the carry and overflow flags, and the two bytes from which the surrounding core derives its negative and zero flags. Register files, instruction decode and flag storage sit outside the block.

In binary mode it is a plain add-with-carry. Subtraction is an add of the complemented operand, so the carry reads as "no borrow". In decimal mode it corrects each nibble for packed BCD. The flags deliberately keep the quirks of classic 8-bit parts. The byte used for the negative flag comes from the intermediate value before the high-nibble correction. The zero byte and the overflow flag come from the uncorrected binary sum or difference. A third operation increments the operand and then subtracts.

All outputs are registered. The results for inputs present at one rising clock edge appear right after that edge.

Top module: `bcd_alu_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, `res`, `cout`, `ovf`, `n_src` and `z_src` read 0 and `zero` reads 1.
- R2: Outputs reflect the inputs sampled at the previous rising edge (one-cycle latency). The operation codes are 2'b00 add, 2'b01 subtract, 2'b10 increment-then-subtract, and 2'b11 behaves exactly like add.
- R3: Binary add (`dec`=0): {`cout`,`res`} = A + M + C. `ovf` is bit 7 of (sum^A)&(sum^M). `n_src` and `z_src` both equal `res`.
- R4: Binary subtract is computed as a binary add of ~M with the same carry. `cout`=1 means no borrow, and `ovf`, `n_src` and `z_src` follow R3 with ~M in place of M.
- R5: Decimal add: low nibble L = A[3:0]+M[3:0]+C, with 6 added when L > 9. The 0x10 carry from L feeds the high sum A[7:4]·16+M[7:4]·16. 0x60 is added when that intermediate exceeds 0x9F, and `cout` is set when the final value exceeds 0xFF. For valid BCD inputs, `res` is the BCD form of (A+M+C) mod 100 and `cout` = (A+M+C ≥ 100).
- R6: Decimal add flags: `n_src` is the low byte of the intermediate before the 0x60 correction. `z_src` and `ovf` come from the plain binary sum A+M+C.
- R7: Decimal subtract: low nibble L = A[3:0]−M[3:0]−(1−C), with 6 subtracted when L is negative. A negative L is sign-extended into the high part before A[7:4]·16−M[7:4]·16 is added. 0x60 is subtracted if the total is negative, and `cout` is 1 exactly when the final total is not negative.
- R8: Decimal subtract flags: `n_src` is the low byte before the 0x60 correction. `z_src` is the low byte of the binary difference D = A−M−(1−C), and `ovf` is bit 7 of (D^A)&(~D^M).
- R9: Increment-then-subtract replaces M with (M+1) mod 256 and then performs subtract in the current mode, so M=0xFF acts as M=0x00.
- R10: `zero` is 1 exactly when `z_src` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc | input | 8 | Accumulator operand A |
| opnd | input | 8 | Memory operand M |
| cin | input | 1 | Carry input C |
| dec | input | 1 | 1 selects packed-BCD arithmetic |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 increment-then-subtract, 11 add |
| res | output | 8 | Result byte |
| cout | output | 1 | Carry out (no-borrow for subtraction) |
| ovf | output | 1 | Overflow flag |
| n_src | output | 8 | Byte the negative flag is taken from |
| z_src | output | 8 | Byte the zero flag is taken from |
| zero | output | 1 | 1 when z_src is zero |

## Verification
The hardest cases to reach are the decimal ones where the three flag sources disagree. These are a low-nibble borrow that sign-extends into the high part, a high correction that changes carry but leaves the negative byte untouched, and non-BCD nibbles that push the intermediate past 0x9F by an unusual route. The stimulus combines directed corner vectors (0x99+0x01, 0x00−0x01, INS with M=0xFF, A-F nibbles) with swept BCD grids and pseudo-random bytes in both modes. Every vector passes through all four operation codes, so the increment and the 2'b11 alias see the same operands.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int WIDE_W = 16;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_INS  = 2'b10,
    OP_ADDX = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              c;
    logic              v;
    logic [BYTE_W-1:0] nsrc;
    logic [BYTE_W-1:0] zsrc;
  } alu_out_t;

  function automatic logic [WIDE_W-1:0] hi_part(input logic [BYTE_W-1:0] x);
    return WIDE_W'({x[BYTE_W-1:NIB_W], {NIB_W{1'b0}}});
  endfunction

  function automatic logic [WIDE_W-1:0] lo_part(input logic [BYTE_W-1:0] x);
    return WIDE_W'(x[NIB_W-1:0]);
  endfunction

  // Binary add; subtraction passes a complemented operand.
  function automatic alu_out_t f_bin_add(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] m,
                                         input logic c);
    alu_out_t o;
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, m} + (BYTE_W+1)'(c);
    o.res  = s[BYTE_W-1:0];
    o.c    = s[BYTE_W];
    o.v    = (s[BYTE_W-1] ^ a[BYTE_W-1]) & (s[BYTE_W-1] ^ m[BYTE_W-1]);
    o.nsrc = s[BYTE_W-1:0];
    o.zsrc = s[BYTE_W-1:0];
    return o;
  endfunction

  function automatic alu_out_t f_dec_add(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] m,
                                         input logic c);
    alu_out_t o;
    logic [WIDE_W-1:0] bin;
    logic [WIDE_W-1:0] t;
    bin = WIDE_W'(a) + WIDE_W'(m) + WIDE_W'(c);
    t   = lo_part(a) + lo_part(m) + WIDE_W'(c);
    if (t > WIDE_W'(9)) t = t + WIDE_W'(6);
    t = lo_part(t[BYTE_W-1:0]) + ((t > WIDE_W'(15)) ? WIDE_W'(16) : '0)
        + hi_part(a) + hi_part(m);
    o.v    = (bin[BYTE_W-1] ^ a[BYTE_W-1]) & (bin[BYTE_W-1] ^ m[BYTE_W-1]);
    o.nsrc = t[BYTE_W-1:0];
    o.zsrc = bin[BYTE_W-1:0];
    if (t > WIDE_W'(16'h9F)) t = t + WIDE_W'(16'h60);
    o.c   = (t > WIDE_W'(16'hFF));
    o.res = t[BYTE_W-1:0];
    return o;
  endfunction

  function automatic alu_out_t f_dec_sub(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] m,
                                         input logic c);
    alu_out_t o;
    logic [WIDE_W-1:0] bin;
    logic [WIDE_W-1:0] t;
    logic              bw;
    bw  = ~c;
    bin = WIDE_W'(a) - WIDE_W'(m) - WIDE_W'(bw);
    t   = lo_part(a) - lo_part(m) - WIDE_W'(bw);
    if (t > WIDE_W'(15)) t = t - WIDE_W'(6);
    t = lo_part(t[BYTE_W-1:0]) | ((t > WIDE_W'(15)) ? {{(WIDE_W-NIB_W){1'b1}}, {NIB_W{1'b0}}} : '0);
    t = t + hi_part(a) - hi_part(m);
    o.v    = (bin[BYTE_W-1] ^ a[BYTE_W-1]) & (~bin[BYTE_W-1] ^ m[BYTE_W-1]);
    o.nsrc = t[BYTE_W-1:0];
    o.zsrc = bin[BYTE_W-1:0];
    if (t > WIDE_W'(16'hFF)) t = t - WIDE_W'(16'h60);
    o.c   = !(t > WIDE_W'(16'hFF));
    o.res = t[BYTE_W-1:0];
    return o;
  endfunction
endpackage

// File: rtl/bcd_alu_operand.sv
module bcd_alu_operand
  import bcd_alu_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [BYTE_W-1:0] opnd,
  output logic [BYTE_W-1:0] m_eff,
  output logic              sub_sel
);
  always_comb begin
    sub_sel = (op == OP_SUB) || (op == OP_INS);
    m_eff   = (op == OP_INS) ? opnd + BYTE_W'(1) : opnd;
  end
endmodule

// File: rtl/bcd_alu_binpath.sv
module bcd_alu_binpath
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] m,
  input  logic              c,
  input  logic              sub_sel,
  output alu_out_t          o
);
  logic [BYTE_W-1:0] m_in;
  assign m_in = sub_sel ? ~m : m;
  assign o    = f_bin_add(a, m_in, c);
endmodule

// File: rtl/bcd_alu_decpath.sv
module bcd_alu_decpath
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] m,
  input  logic              c,
  input  logic              sub_sel,
  output alu_out_t          o
);
  alu_out_t add_o;
  alu_out_t sub_o;
  assign add_o = f_dec_add(a, m, c);
  assign sub_o = f_dec_sub(a, m, c);
  assign o     = sub_sel ? sub_o : add_o;
endmodule

// File: rtl/bcd_alu_top.sv
module bcd_alu_top
  import bcd_alu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] opnd,
  input  logic              cin,
  input  logic              dec,
  input  logic [1:0]        op,
  output logic [BYTE_W-1:0] res,
  output logic              cout,
  output logic              ovf,
  output logic [BYTE_W-1:0] n_src,
  output logic [BYTE_W-1:0] z_src,
  output logic              zero
);
  logic [BYTE_W-1:0] m_eff;
  logic              sub_sel;
  alu_out_t          bin_o;
  alu_out_t          dec_o;
  alu_out_t          nxt;
  logic              nxt_zero;

  bcd_alu_operand u_opnd (.op(op), .opnd(opnd), .m_eff(m_eff), .sub_sel(sub_sel));
  bcd_alu_binpath u_bin  (.a(acc), .m(m_eff), .c(cin), .sub_sel(sub_sel), .o(bin_o));
  bcd_alu_decpath u_dec  (.a(acc), .m(m_eff), .c(cin), .sub_sel(sub_sel), .o(dec_o));

  assign nxt      = dec ? dec_o : bin_o;
  assign nxt_zero = (nxt.zsrc == '0);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res   <= '0;
          cout  <= 1'b0;
          ovf   <= 1'b0;
          n_src <= '0;
          z_src <= '0;
          zero  <= 1'b1;
        end else begin
          res   <= nxt.res;
          cout  <= nxt.c;
          ovf   <= nxt.v;
          n_src <= nxt.nsrc;
          z_src <= nxt.zsrc;
          zero  <= nxt_zero;
        end
      end
    end else begin : g_comb
      assign res   = nxt.res;
      assign cout  = nxt.c;
      assign ovf   = nxt.v;
      assign n_src = nxt.nsrc;
      assign z_src = nxt.zsrc;
      assign zero  = nxt_zero;
    end
  endgenerate
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] acc,
  input logic [7:0] opnd,
  input logic       cin,
  input logic       dec,
  input logic [1:0] op,
  input logic [7:0] res,
  input logic       cout,
  input logic       ovf,
  input logic [7:0] n_src,
  input logic [7:0] z_src,
  input logic       zero
);
  function automatic logic is_bcd(input logic [7:0] x);
    return (x[7:4] < 4'd10) && (x[3:0] < 4'd10);
  endfunction
  function automatic int unsigned bval(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  // R10: zero flag tracks the zero source byte
  a_r10_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (z_src == 8'h00));

  // R3: binary add sum and carry
  a_r3_bin_add: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dec) && ($past(op) == 2'b00 || $past(op) == 2'b11))
    |-> ({cout, res} == 9'($past(acc)) + 9'($past(opnd)) + 9'($past(cin))));

  // R4: binary subtract carry means no borrow
  a_r4_bin_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dec) && $past(op) == 2'b01)
    |-> (cout == (9'($past(acc)) >= 9'($past(opnd)) + 9'(!$past(cin)))));

  // R5: decimal add of valid BCD gives BCD sum and decimal carry
  a_r5_dec_add_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec) && $past(op) == 2'b00 && is_bcd($past(acc)) && is_bcd($past(opnd)))
    |-> (cout == (bval($past(acc)) + bval($past(opnd)) + int'($past(cin)) >= 100)
         && bval(res) == (bval($past(acc)) + bval($past(opnd)) + int'($past(cin))) % 100));

  // R6: decimal add zero byte comes from the binary sum
  a_r6_dec_add_zsrc: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec) && $past(op) == 2'b00)
    |-> (z_src == 8'($past(acc) + $past(opnd) + 8'($past(cin)))));

  // R9: increment-then-subtract in binary mode
  a_r9_ins_binary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dec) && $past(op) == 2'b10)
    |-> (res == 8'($past(acc) - ($past(opnd) + 8'd1) - 8'(!$past(cin)))));
endmodule

bind bcd_alu_top bcd_alu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc(acc), .opnd(opnd), .cin(cin), .dec(dec), .op(op),
  .res(res), .cout(cout), .ovf(ovf), .n_src(n_src), .z_src(z_src), .zero(zero)
);

// File: tb/bcd_alu_tb.sv
module bcd_alu_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc = '0;
  logic [7:0] opnd = '0;
  logic       cin = 1'b0;
  logic       dec = 1'b0;
  logic [1:0] op = '0;
  logic [7:0] res, n_src, z_src;
  logic       cout, ovf, zero;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    res, cy, v, ns, zs, zf;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_alu_top dut_i (.clk(clk), .rst_n(rst_n), .acc(acc), .opnd(opnd), .cin(cin),
    .dec(dec), .op(op), .res(res), .cout(cout), .ovf(ovf), .n_src(n_src),
    .z_src(z_src), .zero(zero));

  // Reference model written in plain integer arithmetic.
  function automatic void model(input int a, input int m0, input int c, input int d,
                                input int opc, output exp_t e);
    int m, bw, s, lo, t, dd, mm;
    bit sub;
    sub = (opc == 1) || (opc == 2);
    m   = (opc == 2) ? (m0 + 1) % 256 : m0;
    if (d == 0) begin
      mm     = sub ? 255 - m : m;
      s      = a + mm + c;
      e.res  = s % 256;
      e.cy   = s / 256;
      e.v    = (((a ^ s) & (mm ^ s) & 128) != 0) ? 1 : 0;
      e.ns   = e.res;
      e.zs   = e.res;
    end else if (!sub) begin
      s    = a + m + c;
      e.zs = s % 256;
      e.v  = (((a ^ s) & (m ^ s) & 128) != 0) ? 1 : 0;
      lo   = a % 16 + m % 16 + c;
      if (lo > 9) lo = lo + 6;
      t    = (a / 16) * 16 + (m / 16) * 16 + ((lo > 15) ? 16 : 0) + lo % 16;
      e.ns = t % 256;
      if (t > 159) t = t + 96;
      e.cy  = (t > 255) ? 1 : 0;
      e.res = t % 256;
    end else begin
      bw   = 1 - c;
      dd   = a - m - bw;
      e.zs = dd & 255;
      e.v  = (((a ^ dd) & (~dd ^ m) & 128) != 0) ? 1 : 0;
      lo   = a % 16 - m % 16 - bw;
      if (lo < 0) lo = lo - 6;
      t    = (lo & 15) - ((lo < 0) ? 16 : 0) + (a / 16) * 16 - (m / 16) * 16;
      e.ns = t & 255;
      if (t < 0) t = t - 96;
      e.cy  = (t >= 0) ? 1 : 0;
      e.res = t & 255;
    end
    e.zf = (e.zs == 0) ? 1 : 0;
  endfunction

  task automatic drive(input int a, input int m, input int c, input int d, input int opc,
                       input string tag);
    exp_t e;
    @(negedge clk);
    acc = 8'(a); opnd = 8'(m); cin = c[0]; dec = d[0]; op = 2'(opc);
    model(a, m, c, d, opc, e);
    e.cyc = cyc;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive_all_ops(input int a, input int m, input int c, input int d,
                               input string tag);
    for (int k = 0; k < 4; k++) drive(a, m, c, d, k, tag);
  endtask

  // Monitor: compares each expected item one cycle after it was driven.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc < cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (int'(res) != e.res || int'(cout) != e.cy || int'(ovf) != e.v ||
          int'(n_src) != e.ns || int'(z_src) != e.zs || int'(zero) != e.zf) begin
        errors++;
        $display("FAIL %s: act res=%02h c=%0d v=%0d n=%02h z=%02h zf=%0d exp res=%02h c=%0d v=%0d n=%02h z=%02h zf=%0d",
          e.tag, res, cout, ovf, n_src, z_src, zero, e.res, e.cy, e.v, e.ns, e.zs, e.zf);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (res !== 8'h00 || cout !== 1'b0 || ovf !== 1'b0 || n_src !== 8'h00 ||
        z_src !== 8'h00 || zero !== 1'b1) begin
      errors++;
      $display("FAIL %s: act res=%02h c=%b v=%b n=%02h z=%02h zf=%b exp all zero, zf=1",
        tag, res, cout, ovf, n_src, z_src, zero);
    end
  endtask

  initial begin
    int seed;
    acc = 8'h99; opnd = 8'h77; cin = 1'b1; dec = 1'b1; op = 2'b01;
    repeat (3) @(negedge clk);
    check_reset("R1 in reset");
    rst_n = 1'b1;
    check_reset("R1 after release before edge");
    // directed corners
    drive_all_ops(8'h99, 8'h01, 0, 1, "R5 R7 R9 99/01 dec");
    drive_all_ops(8'h00, 8'h01, 0, 1, "R7 R8 borrow sign-extend");
    drive_all_ops(8'h00, 8'h00, 1, 1, "R10 zero source dec");
    drive_all_ops(8'h50, 8'h50, 0, 1, "R6 high correction");
    drive_all_ops(8'h7F, 8'h01, 0, 0, "R3 overflow");
    drive_all_ops(8'h80, 8'h01, 1, 0, "R4 sub overflow");
    drive_all_ops(8'h12, 8'hFF, 1, 1, "R9 M=FF dec");
    drive_all_ops(8'h12, 8'hFF, 1, 0, "R9 M=FF bin");
    drive_all_ops(8'hFA, 8'hCB, 1, 1, "R6 R8 non-BCD nibbles");
    drive_all_ops(8'h00, 8'h00, 0, 0, "R10 zero bin");
    drive(8'h45, 8'h27, 1, 0, 3, "R2 opcode 11 aliases add");
    // BCD grid sweep in decimal mode
    for (int i = 0; i < 100; i += 7)
      for (int j = 0; j < 100; j += 9)
        drive_all_ops((i / 10) * 16 + i % 10, (j / 10) * 16 + j % 10, (i + j) & 1, 1,
                      "R5 R6 R7 R8 BCD grid");
    // pseudo-random bytes in both modes
    seed = 32'h1ACE;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 1103515245 + 12345;
      drive_all_ops((seed >> 8) & 255, (seed >> 16) & 255, (seed >> 5) & 1, (seed >> 24) & 1,
                    "R2 R3 R4 R7 R8 R9 random");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule